// File: doc/BRIEF.md
# Lane-Split SIMD Arithmetic Stage with Saturation

This block is the arithmetic stage of a 32-bit datapath. Each cycle it takes two operands and an operation code, and it produces a result in the same cycle. The result comes from one full-width adder. That adder can run as a single 32-bit word, as two 16-bit halves, or as four 8-bit bytes. The carry is cut at the lane edges the mode selects. On top of the adder sit a per-lane clamp for saturating arithmetic, a byte-wise select, a halfword pack, and a doubling path that saturates to the signed word range.

The block holds two pieces of state. The first is a four-bit NZCV word. Only word-wide add-class operations that ask for it write this word. The second is four per-byte greater-or-equal bits. Lane add-class operations write these bits, and the select operation later reads them. An operation writes state only when `op_valid` is high at a rising clock edge. The result output is combinational and does not depend on `op_valid`.

Top module: `simd_alu`

## Requirements
- R1: A rising edge with `rst_n` low clears `nzcv` to 0 and `ge` to 0.
- R2: Opcode 0 (add) and opcode 1 (subtract) wrap inside each lane, and no carry or borrow crosses a lane edge. Lane mode 0 is one 32-bit word, 1 is two 16-bit halves, 2 is four bytes, and 3 behaves as mode 0.
- R3: With `sign_mode`=1, opcode 2 (saturating add) and opcode 3 (saturating subtract) clamp each lane to its signed range. For bytes that range is 0x80..0x7F, for halves 0x8000..0x7FFF and for the word 0x80000000..0x7FFFFFFF.
- R4: With `sign_mode`=0, opcodes 2 and 3 clamp each lane to the range from 0 to the all-ones lane value.
- R5: A valid opcode 0..3 in lane mode 1 or 2 writes `ge`. Bit i belongs to byte i (bits 8i+7..8i), and every bit of a lane takes that lane's value. For unsigned operations the value is the lane carry out: for add this is the carry, for subtract it means no borrow (a >= b). For signed operations the value is 1 when the exact lane result is >= 0.
- R6: Opcode 4 (select) takes byte i from `src_a` when `ge[i]`=1 and from `src_b` when `ge[i]`=0.
- R7: Opcode 5 (pack) returns `src_b[31:16]` above `src_a[15:0]`.
- R8: Opcode 6 doubles `src_a` and clamps the result to 0x80000000..0x7FFFFFFF.
- R9: A valid opcode 0..3 in word mode with `set_flags`=1 writes `nzcv` from the result. The bits are N (bit 3, result bit 31), Z (bit 2, result is zero), C (bit 1, carry out, which for subtract means no borrow) and V (bit 0, signed overflow of the unclamped sum).
- R10: `nzcv` holds its value across lane operations, across word operations with `set_flags`=0, and across any cycle with `op_valid`=0. `ge` holds its value across word-mode operations and across cycles with `op_valid`=0.
- R11: Opcode 7 outputs zero and changes neither `nzcv` nor `ge`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Allows this cycle's operation to update the flag state |
| op_code | input | 3 | Operation select, encoded as listed in the requirements |
| lane_mode | input | 2 | 0 word, 1 halves, 2 bytes, 3 word |
| sign_mode | input | 1 | 1 selects signed saturation and signed ge |
| set_flags | input | 1 | Asks a word add-class operation to write nzcv |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| result | output | 32 | Combinational result |
| nzcv | output | 4 | Registered N, Z, C and V flags |
| ge | output | 4 | Registered per-byte greater-or-equal bits |

## Verification
If the carry is cut at the wrong boundary, `result` is wrong in the same cycle. A carry of 0xFF + 1 that leaks into the next byte, or that stops at a byte edge in word mode, shows up at once. A wrong lane-top choice in the clamp gives 0xFF where 0x7F is expected. Faulty ge or nzcv state is stored at the next edge and can be read directly on the ports one cycle later. A bad ge value also reappears as wrongly chosen bytes in the next select. Write enables that fire when they should not appear as changed flags after cycles that should have left them alone.

// File: rtl/simd_alu_pkg.sv
// Shared encodings for the lane-split arithmetic stage.
package simd_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_QADD = 3'd2,
        OP_QSUB = 3'd3,
        OP_SEL  = 3'd4,
        OP_PACK = 3'd5,
        OP_QDBL = 3'd6,
        OP_NOP  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        LM_WORD = 2'd0,
        LM_HALF = 2'd1,
        LM_BYTE = 2'd2,
        LM_WIDE = 2'd3
    } lane_mode_e;
endpackage

// File: rtl/simd_lane_adder.sv
// One adder made of byte slices. The carry chain is cut at every byte edge in
// byte mode and at the middle in half mode. It reports the carry, the signed
// overflow and the exact sign of the lane each byte belongs to.
// Assumes lanes are contiguous and that a lane's top byte sits at its high end.
module simd_lane_adder
    import simd_alu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NUM_B  = 4
) (
    input  logic [BYTE_W*NUM_B-1:0] a,
    input  logic [BYTE_W*NUM_B-1:0] b,
    input  logic                    sub,
    input  lane_mode_e              mode,
    output logic [BYTE_W*NUM_B-1:0] sum,
    output logic [NUM_B-1:0]        lane_top,
    output logic [NUM_B-1:0]        lane_cy,
    output logic [NUM_B-1:0]        lane_ov,
    output logic [NUM_B-1:0]        lane_neg
);
    localparam int MID = NUM_B / 2;

    logic [NUM_B-1:0] brk;
    logic [NUM_B-1:0] cy_b;
    logic [NUM_B-1:0] ov_b;

    // Where a new lane starts: byte 0 always, every byte in byte mode, the middle in half mode.
    always_comb begin
        for (int i = 0; i < NUM_B; i++) begin
            brk[i] = (i == 0) || (mode == LM_BYTE) || ((mode == LM_HALF) && (i == MID));
        end
        for (int i = 0; i < NUM_B; i++) begin
            lane_top[i] = (i == NUM_B - 1) ? 1'b1 : brk[(i + 1) % NUM_B];
        end
    end

    // Byte-slice adds with the carry cut at lane starts.
    always_comb begin
        logic               c;
        logic [BYTE_W-1:0]  ai;
        logic [BYTE_W-1:0]  bi;
        logic [BYTE_W:0]    t;
        c = 1'b0;
        for (int i = 0; i < NUM_B; i++) begin
            ai = a[i*BYTE_W +: BYTE_W];
            bi = sub ? ~b[i*BYTE_W +: BYTE_W] : b[i*BYTE_W +: BYTE_W];
            t  = {1'b0, ai} + {1'b0, bi} + {{BYTE_W{1'b0}}, (brk[i] ? sub : c)};
            c  = t[BYTE_W];
            sum[i*BYTE_W +: BYTE_W] = t[BYTE_W-1:0];
            cy_b[i] = t[BYTE_W];
            ov_b[i] = (ai[BYTE_W-1] == bi[BYTE_W-1]) && (t[BYTE_W-1] != ai[BYTE_W-1]);
        end
    end

    // Copy each lane's top-byte status down to every byte of that lane.
    always_comb begin
        for (int i = NUM_B - 1; i >= 0; i--) begin
            if (lane_top[i]) begin
                lane_cy[i]  = cy_b[i];
                lane_ov[i]  = ov_b[i];
                lane_neg[i] = sum[i*BYTE_W + BYTE_W - 1] ^ ov_b[i];
            end else begin
                lane_cy[i]  = lane_cy[(i + 1) % NUM_B];
                lane_ov[i]  = lane_ov[(i + 1) % NUM_B];
                lane_neg[i] = lane_neg[(i + 1) % NUM_B];
            end
        end
    end
endmodule

// File: rtl/simd_lane_sat.sv
// Per-byte clamp stage. It replaces each byte of a lane that overflowed with
// the matching byte of the lane's bound, signed or unsigned.
// Assumes the lane status inputs were already copied to every byte of the lane.
module simd_lane_sat #(
    parameter int BYTE_W = 8,
    parameter int NUM_B  = 4
) (
    input  logic [BYTE_W*NUM_B-1:0] sum,
    input  logic [NUM_B-1:0]        lane_top,
    input  logic [NUM_B-1:0]        lane_cy,
    input  logic [NUM_B-1:0]        lane_ov,
    input  logic [NUM_B-1:0]        lane_neg,
    input  logic                    sub,
    input  logic                    is_signed,
    output logic [BYTE_W*NUM_B-1:0] clamped
);
    localparam logic [BYTE_W-1:0] ALL1 = {BYTE_W{1'b1}};
    localparam logic [BYTE_W-1:0] SMAX = {1'b0, {(BYTE_W-1){1'b1}}};
    localparam logic [BYTE_W-1:0] SMIN = {1'b1, {(BYTE_W-1){1'b0}}};

    for (genvar i = 0; i < NUM_B; i++) begin : g_byte
        logic hi, lo;
        // Pick the clamp direction for this byte's lane.
        always_comb begin
            hi = is_signed ? (lane_ov[i] && !lane_neg[i]) : (!sub && lane_cy[i]);
            lo = is_signed ? (lane_ov[i] &&  lane_neg[i]) : ( sub && !lane_cy[i]);
        end
        // Substitute the bound byte when the lane is out of range.
        always_comb begin
            if (hi)
                clamped[i*BYTE_W +: BYTE_W] = (is_signed && lane_top[i]) ? SMAX : ALL1;
            else if (lo)
                clamped[i*BYTE_W +: BYTE_W] = (is_signed && lane_top[i]) ? SMIN : '0;
            else
                clamped[i*BYTE_W +: BYTE_W] = sum[i*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/simd_flag_regs.sv
// Holds the NZCV word and the per-byte greater-or-equal bits.
// Assumes the write enables are already qualified by the operation's valid.
module simd_flag_regs #(
    parameter int NUM_B = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nz_we,
    input  logic [3:0]       nzcv_d,
    input  logic             ge_we,
    input  logic [NUM_B-1:0] ge_d,
    output logic [3:0]       nzcv_q,
    output logic [NUM_B-1:0] ge_q
);
    // Flag storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nzcv_q <= '0;
            ge_q   <= '0;
        end else begin
            if (nz_we) nzcv_q <= nzcv_d;
            if (ge_we) ge_q   <= ge_d;
        end
    end
endmodule

// File: rtl/simd_alu.sv
// Lane-split arithmetic stage. The result is combinational. NZCV and the
// greater-or-equal bits are registered state that valid operations write.
// Assumes DW = BYTE_W*NUM_B and that NUM_B is even so that half mode exists.
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NUM_B  = 4,
    parameter int DW     = BYTE_W * NUM_B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [1:0]    lane_mode,
    input  logic          sign_mode,
    input  logic          set_flags,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic [DW-1:0] result,
    output logic [3:0]    nzcv,
    output logic [NUM_B-1:0] ge
);
    localparam int HW = DW / 2;

    alu_op_e          op;
    lane_mode_e       lm;
    logic             is_sub, is_arith, is_lane;
    logic [DW-1:0]    sum, clamped, dbl, sel_res;
    logic [NUM_B-1:0] top, cy, ov, neg, ge_new;

    // Decode the operation class.
    always_comb begin
        op       = alu_op_e'(op_code);
        lm       = lane_mode_e'(lane_mode);
        is_sub   = (op == OP_SUB) || (op == OP_QSUB);
        is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_QADD) || (op == OP_QSUB);
        is_lane  = (lm == LM_HALF) || (lm == LM_BYTE);
    end

    simd_lane_adder #(.BYTE_W(BYTE_W), .NUM_B(NUM_B)) u_add (
        .a(src_a), .b(src_b), .sub(is_sub), .mode(lm), .sum(sum),
        .lane_top(top), .lane_cy(cy), .lane_ov(ov), .lane_neg(neg)
    );

    simd_lane_sat #(.BYTE_W(BYTE_W), .NUM_B(NUM_B)) u_sat (
        .sum(sum), .lane_top(top), .lane_cy(cy), .lane_ov(ov), .lane_neg(neg),
        .sub(is_sub), .is_signed(sign_mode), .clamped(clamped)
    );

    // Doubling with a clamp to the signed word range.
    always_comb begin
        if (src_a[DW-1] != src_a[DW-2])
            dbl = {src_a[DW-1], {(DW-1){~src_a[DW-1]}}};
        else
            dbl = {src_a[DW-2:0], 1'b0};
    end

    // Choose each byte of the select result from the stored ge bits.
    always_comb begin
        for (int i = 0; i < NUM_B; i++)
            sel_res[i*BYTE_W +: BYTE_W] = ge[i] ? src_a[i*BYTE_W +: BYTE_W]
                                                : src_b[i*BYTE_W +: BYTE_W];
    end

    // Per-byte greater-or-equal value from the lane status.
    always_comb begin
        for (int i = 0; i < NUM_B; i++)
            ge_new[i] = sign_mode ? ~neg[i] : cy[i];
    end

    // Final result multiplexer.
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:   result = sum;
            OP_QADD, OP_QSUB: result = clamped;
            OP_SEL:           result = sel_res;
            OP_PACK:          result = {src_b[DW-1:HW], src_a[HW-1:0]};
            OP_QDBL:          result = dbl;
            default:          result = '0;
        endcase
    end

    simd_flag_regs #(.NUM_B(NUM_B)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .nz_we(op_valid && is_arith && !is_lane && set_flags),
        .nzcv_d({result[DW-1], (result == '0), cy[NUM_B-1], ov[NUM_B-1]}),
        .ge_we(op_valid && is_arith && is_lane),
        .ge_d(ge_new),
        .nzcv_q(nzcv), .ge_q(ge)
    );
endmodule

// File: rtl/simd_alu_chk.sv
// Property checker for simd_alu, attached with bind.
module simd_alu_chk #(
    parameter int BYTE_W = 8,
    parameter int NUM_B  = 4,
    parameter int DW     = BYTE_W * NUM_B
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [1:0]       lane_mode,
    input logic             sign_mode,
    input logic             set_flags,
    input logic [DW-1:0]    src_a,
    input logic [DW-1:0]    src_b,
    input logic [DW-1:0]    result,
    input logic [3:0]       nzcv,
    input logic [NUM_B-1:0] ge
);
    localparam int HW = DW / 2;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (nzcv == 4'd0 && ge == '0));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(nzcv) && $stable(ge)));

    assert_lane_keeps_nzcv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode == 2'd1 || lane_mode == 2'd2) |=> $stable(nzcv));

    assert_word_keeps_ge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode == 2'd0 || lane_mode == 2'd3) |=> $stable(ge));

    assert_nop_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd7) |=> ($stable(nzcv) && $stable(ge)));

    assert_pack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd5) |-> (result == {src_b[DW-1:HW], src_a[HW-1:0]}));

    assert_dbl_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd6) |-> (result[DW-1] == src_a[DW-1]));

    assert_word_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd2 && lane_mode == 2'd0 && sign_mode && result != src_a + src_b)
        |-> (result == {1'b0, {(DW-1){1'b1}}} || result == {1'b1, {(DW-1){1'b0}}}));

    for (genvar i = 0; i < NUM_B; i++) begin : g_sel
        assert_select_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code == 3'd4) |-> (result[i*BYTE_W +: BYTE_W] ==
                (ge[i] ? src_a[i*BYTE_W +: BYTE_W] : src_b[i*BYTE_W +: BYTE_W])));
    end
endmodule

bind simd_alu simd_alu_chk #(.BYTE_W(BYTE_W), .NUM_B(NUM_B), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .lane_mode(lane_mode), .sign_mode(sign_mode), .set_flags(set_flags),
    .src_a(src_a), .src_b(src_b), .result(result), .nzcv(nzcv), .ge(ge)
);

// File: tb/test_simd_alu.sv
`timescale 1ns/1ps
module test_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [1:0]  lane_mode = 2'd0;
    logic        sign_mode = 1'b0;
    logic        set_flags = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] result;
    logic [3:0]  nzcv;
    logic [3:0]  ge;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd_alu i_simd_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .lane_mode(lane_mode), .sign_mode(sign_mode), .set_flags(set_flags),
        .src_a(src_a), .src_b(src_b), .result(result), .nzcv(nzcv), .ge(ge)
    );

    // {op, lane, signed, a, b, expected result}
    localparam int NV = 20;
    localparam logic [101:0] VEC [NV] = '{
        {3'd0, 2'd2, 1'b0, 32'h000000FF, 32'h00000001, 32'h00000000}, // R2
        {3'd0, 2'd1, 1'b0, 32'h0000FFFF, 32'h00000001, 32'h00000000}, // R2
        {3'd0, 2'd0, 1'b0, 32'h0000FFFF, 32'h00000001, 32'h00010000}, // R2
        {3'd1, 2'd2, 1'b0, 32'h01020304, 32'h02020202, 32'hFF000102}, // R2
        {3'd1, 2'd1, 1'b0, 32'h00010000, 32'h00000001, 32'h0001FFFF}, // R2
        {3'd2, 2'd2, 1'b1, 32'h7F80107F, 32'h01FF1001, 32'h7F80207F}, // R3
        {3'd2, 2'd1, 1'b1, 32'h7FFF8000, 32'h00018000, 32'h7FFF8000}, // R3
        {3'd2, 2'd0, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF}, // R3
        {3'd3, 2'd0, 1'b1, 32'h80000000, 32'h00000001, 32'h80000000}, // R3
        {3'd2, 2'd2, 1'b0, 32'hF0011020, 32'h20FE0101, 32'hFFFF1121}, // R4
        {3'd3, 2'd1, 1'b0, 32'h00051000, 32'h00060FFF, 32'h00000001}, // R4
        {3'd3, 2'd2, 1'b1, 32'h80007F10, 32'h0101FF20, 32'h80FF7FF0}, // R3
        {3'd5, 2'd0, 1'b0, 32'h1111AAAA, 32'hBBBB2222, 32'hBBBBAAAA}, // R7
        {3'd6, 2'd0, 1'b0, 32'h40000000, 32'h00000000, 32'h7FFFFFFF}, // R8
        {3'd6, 2'd0, 1'b0, 32'hC0000000, 32'h00000000, 32'h80000000}, // R8
        {3'd6, 2'd0, 1'b0, 32'hBFFFFFFF, 32'h00000000, 32'h80000000}, // R8
        {3'd6, 2'd0, 1'b0, 32'h12345678, 32'h00000000, 32'h2468ACF0}, // R8
        {3'd7, 2'd0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}, // R11
        {3'd2, 2'd0, 1'b0, 32'hFFFFFFF0, 32'h00000020, 32'hFFFFFFFF}, // R4
        {3'd0, 2'd3, 1'b0, 32'h0000FFFF, 32'h00000001, 32'h00010000}  // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge.
    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] lm,
                         input logic s, input logic sf, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = v; op_code = op; lane_mode = lm; sign_mode = s; set_flags = sf;
        src_a = a; src_b = b;
    endtask

    // Let the edge pass, then check the state one falling edge later.
    task automatic settle();
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 nzcv", {28'd0, nzcv}, 32'd0);
        check("R1 ge", {28'd0, ge}, 32'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(1'b0, VEC[k][101:99], VEC[k][98:97], VEC[k][96], 1'b0,
                  VEC[k][95:64], VEC[k][63:32]);
            #1;
            check($sformatf("R2/R3/R4/R7/R8/R11 vector %0d", k), result, VEC[k][31:0]);
        end

        // R5 unsigned byte subtract: ge = a>=b per byte
        drive(1'b1, 3'd1, 2'd2, 1'b0, 1'b1, 32'h05010A00, 32'h03020A01);
        settle();
        check("R5 ge byte sub", {28'd0, ge}, 32'hA);
        check("R10 nzcv after lane op", {28'd0, nzcv}, 32'd0);

        // R6 select from stored ge
        drive(1'b0, 3'd4, 2'd0, 1'b0, 1'b0, 32'hAABBCCDD, 32'h11223344);
        #1;
        check("R6 select", result, 32'hAA22CC44);

        // R5 signed half add: exact sign decides
        drive(1'b1, 3'd0, 2'd1, 1'b1, 1'b0, 32'h7FFF0001, 32'h0001FFFE);
        settle();
        check("R5 ge signed half", {28'd0, ge}, 32'hC);

        // R5 unsigned half add carries
        drive(1'b1, 3'd0, 2'd1, 1'b0, 1'b0, 32'h80000001, 32'h8000FFFF);
        settle();
        check("R5 ge unsigned half", {28'd0, ge}, 32'hF);

        // R9 word flags
        drive(1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000001);
        settle();
        check("R9 nzcv add carry zero", {28'd0, nzcv}, 32'h6);
        check("R10 ge kept by word op", {28'd0, ge}, 32'hF);

        drive(1'b1, 3'd1, 2'd0, 1'b0, 1'b1, 32'h00000001, 32'h00000002);
        settle();
        check("R9 nzcv sub borrow", {28'd0, nzcv}, 32'h8);

        drive(1'b1, 3'd0, 2'd0, 1'b1, 1'b1, 32'h7FFFFFFF, 32'h00000001);
        settle();
        check("R9 nzcv overflow", {28'd0, nzcv}, 32'h9);

        // R10 word op without set_flags leaves nzcv
        drive(1'b1, 3'd0, 2'd0, 1'b0, 1'b0, 32'h00000000, 32'h00000000);
        settle();
        check("R10 nzcv no set_flags", {28'd0, nzcv}, 32'h9);

        // R10 lane op with set_flags leaves nzcv, writes ge
        drive(1'b1, 3'd0, 2'd2, 1'b0, 1'b1, 32'h01010101, 32'hFF00FF00);
        settle();
        check("R10 nzcv lane op", {28'd0, nzcv}, 32'h9);
        check("R5 ge byte add", {28'd0, ge}, 32'hA);

        // R10 invalid cycle changes nothing
        drive(1'b0, 3'd1, 2'd2, 1'b0, 1'b1, 32'h00000000, 32'h01010101);
        settle();
        check("R10 ge idle", {28'd0, ge}, 32'hA);
        check("R10 nzcv idle", {28'd0, nzcv}, 32'h9);

        // R11 reserved opcode is inert
        drive(1'b1, 3'd7, 2'd2, 1'b0, 1'b1, 32'h00000000, 32'h01010101);
        #1;
        check("R11 result", result, 32'h0);
        settle();
        check("R11 ge", {28'd0, ge}, 32'hA);
        check("R11 nzcv", {28'd0, nzcv}, 32'h9);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 nzcv mid-run", {28'd0, nzcv}, 32'd0);
        check("R1 ge mid-run", {28'd0, ge}, 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule